// File: doc/BRIEF.md
# Cluster Result Combine, Pool and Activation Unit

This unit sits behind four processing clusters that each deliver one 18-bit signed partial result for each of four kernels on the same beat. Depending on how deep the layer's accumulation is, the unit keeps each cluster's result as a separate feature, adds clusters in pairs, or adds all four into one feature per kernel. When the depth needs more than one pass through the clusters, partial totals are held in per-lane accumulators until the beat flagged as the final pass arrives.

The completed feature then goes through an optional pooling stage. This stage either keeps a running maximum or a running sum over a window of features. It is followed by an optional ReLU, an arithmetic right shift with round-to-nearest, and saturation to a signed 8-bit value. With pooling enabled, only the pooled value is emitted, on the beat flagged as the last of the window. Mode controls arrive from the central controller alongside each beat.

A four-state machine tracks which per-lane registers hold live data.
- ST_IDLE: nothing held.
- ST_ACC: a partial pass sum is held.
- ST_POOL: a pooled value is held.
- ST_BOTH: both are held.

On a valid beat the transitions are as follows.
- A non-final pass moves ST_IDLE or ST_ACC to ST_ACC, and ST_POOL or ST_BOTH to ST_BOTH.
- A final pass with pooling enabled and not the end of the window moves any state to ST_POOL.
- Any other final pass returns to ST_IDLE.

Without a valid beat the state holds.

Top module: `feature_combine_unit`

## Requirements
- R1: While rst_n is low, and after it is released, out_valid is 0 and out_data is all zeros until the first emitting beat.
- R2: With cfg_group=0, output lane k*4+c carries the result of cluster c for kernel k. The input field for cluster c, kernel k sits at in_data[(c*4+k)*18 +: 18], and output lane L sits at out_data[L*8 +: 8].
- R3: With cfg_group=1, lane k*4+0 carries cluster0+cluster1 and lane k*4+1 carries cluster2+cluster3 for kernel k. Lanes k*4+2 and k*4+3 carry 0.
- R4: With cfg_group=2 (and 3), lane k*4+0 carries the sum of all four clusters for kernel k, and the other three lanes of that kernel carry 0.
- R5: A valid beat with in_pass_last=0 adds its combined values into per-lane accumulators and emits nothing. The next beat with in_pass_last=1 uses the accumulated total plus its own values, and then clears the accumulators.
- R6: With cfg_pool=1 (max), final-pass beats with in_win_last=0 emit nothing. The beat with in_win_last=1 emits the maximum of all features in the window, starting from the first one.
- R7: With cfg_pool=2 (average), the emitted value is the window sum arithmetically shifted right by cfg_pool_log2, rounding toward minus infinity.
- R8: After a window closes, the next window's result depends only on its own features.
- R9: With cfg_relu=1, negative features become 0 before requantization. With cfg_relu=0 they pass unchanged.
- R10: Requantization gives (x + 2^(s-1)) >>> s for s = cfg_shift > 0, and gives x unchanged for s = 0.
- R11: Requantized values above 127 are emitted as 127, and values below -128 are emitted as -128.
- R12: out_valid is a one-cycle pulse in the cycle after an emitting beat, and out_data holds its value until the next emission.
- R13: in_win_last has no effect when pooling is off (cfg_pool=0 or 3), and none on beats with in_pass_last=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Beat of cluster results present |
| in_data | input | 288 | Sixteen 18-bit signed results, cluster-major |
| in_pass_last | input | 1 | Beat is the final accumulation pass |
| in_win_last | input | 1 | Beat closes the pooling window |
| cfg_group | input | 2 | 0 per cluster, 1 pairs, 2/3 all four |
| cfg_pool | input | 2 | 0 none, 1 max, 2 average, 3 none |
| cfg_pool_log2 | input | 2 | log2 of the average window size |
| cfg_relu | input | 1 | Enable ReLU |
| cfg_shift | input | 4 | Requantization right shift |
| out_valid | output | 1 | Pulse: new features on out_data |
| out_data | output | 128 | Sixteen signed 8-bit features |

## Verification
The closing pass of a multi-pass accumulation and the closing of a pooling window can fall on the same beat. In that case the accumulator total, the new beat's values and the stored pool value are all merged in one cycle. The bench provokes this with a max-pool window of two features, each built from two passes in four-cluster mode, where the last beat carries both the final-pass and end-of-window flags. The emitted values are judged against a model that completes each feature's total before taking the maximum, and the unused lanes must stay at zero.

// File: rtl/fcu_pkg.sv
package fcu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ACC  = 2'b01,
        ST_POOL = 2'b10,
        ST_BOTH = 2'b11
    } fcu_state_t;

    localparam logic [1:0] GRP_ONE  = 2'd0;
    localparam logic [1:0] GRP_PAIR = 2'd1;
    localparam logic [1:0] GRP_QUAD = 2'd2;

    localparam logic [1:0] POOL_NONE = 2'd0;
    localparam logic [1:0] POOL_MAX  = 2'd1;
    localparam logic [1:0] POOL_AVG  = 2'd2;

endpackage

// File: rtl/fcu_ctrl.sv
module fcu_ctrl
    import fcu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic pass_last,
    input  logic win_last,
    input  logic pool_on,
    output logic use_acc,
    output logic use_pool,
    output logic acc_load,
    output logic pool_load,
    output logic emit
);

    fcu_state_t state, state_d;
    logic       pool_stays;

    assign pool_stays = pool_on && !win_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        state_d = state;
        if (in_valid) begin
            unique case (state)
                ST_IDLE, ST_ACC:
                    state_d = !pass_last ? ST_ACC
                            : (pool_stays ? ST_POOL : ST_IDLE);
                ST_POOL, ST_BOTH:
                    state_d = !pass_last ? ST_BOTH
                            : (pool_stays ? ST_POOL : ST_IDLE);
            endcase
        end
    end

    always_comb begin
        use_acc  = 1'b0;
        use_pool = 1'b0;
        unique case (state)
            ST_IDLE: begin use_acc = 1'b0; use_pool = 1'b0; end
            ST_ACC:  begin use_acc = 1'b1; use_pool = 1'b0; end
            ST_POOL: begin use_acc = 1'b0; use_pool = 1'b1; end
            ST_BOTH: begin use_acc = 1'b1; use_pool = 1'b1; end
        endcase
        acc_load  = in_valid && !pass_last;
        pool_load = in_valid && pass_last && pool_stays;
        emit      = in_valid && pass_last && !pool_stays;
    end

    // R5: a non-final pass leaves a partial sum held
    assert_acc_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !pass_last) |=> (state == ST_ACC || state == ST_BOTH));

    // R13: with pooling off a final pass always empties the unit
    assert_flush_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pass_last && !pool_on) |=> (state == ST_IDLE));

endmodule

// File: rtl/fcu_combine.sv
module fcu_combine
    import fcu_pkg::*;
#(
    parameter int N_KER = 4,
    parameter int RES_W = 18,
    parameter int SUM_W = 20
) (
    input  logic [N_KER*4*RES_W-1:0] in_res,
    input  logic [1:0]               grp,
    output logic [N_KER*4*SUM_W-1:0] lanes
);

    localparam int N_CL = 4;

    for (genvar k = 0; k < N_KER; k++) begin : g_ker
        logic signed [SUM_W-1:0] e [N_CL];
        logic signed [SUM_W-1:0] s [N_CL];

        for (genvar c = 0; c < N_CL; c++) begin : g_ext
            assign e[c] = SUM_W'($signed(in_res[(c*N_KER+k)*RES_W +: RES_W]));
            assign lanes[(k*N_CL+c)*SUM_W +: SUM_W] = s[c];
        end

        always_comb begin
            for (int c = 0; c < N_CL; c++) s[c] = '0;
            unique case (grp)
                GRP_ONE: begin
                    for (int c = 0; c < N_CL; c++) s[c] = e[c];
                end
                GRP_PAIR: begin
                    s[0] = e[0] + e[1];
                    s[1] = e[2] + e[3];
                end
                GRP_QUAD, 2'd3: begin
                    s[0] = e[0] + e[1] + e[2] + e[3];
                end
            endcase
        end
    end

endmodule

// File: rtl/fcu_post.sv
module fcu_post #(
    parameter int POOL_W = 35,
    parameter int LOG_W  = 2,
    parameter int SH_W   = 4,
    parameter int OUT_W  = 8
) (
    input  logic signed [POOL_W-1:0] val,
    input  logic                     avg_en,
    input  logic [LOG_W-1:0]         pool_log2,
    input  logic                     relu,
    input  logic [SH_W-1:0]          shift,
    output logic [OUT_W-1:0]         q
);

    localparam logic signed [POOL_W:0] SAT_HI = (POOL_W+1)'((1 << (OUT_W-1)) - 1);
    localparam logic signed [POOL_W:0] SAT_LO = -SAT_HI - 1;

    logic signed [POOL_W-1:0] avg_v, act_v;
    logic        [POOL_W:0]   bias;
    logic signed [POOL_W:0]   rounded;

    always_comb begin
        avg_v   = avg_en ? (val >>> pool_log2) : val;
        act_v   = (relu && avg_v < 0) ? '0 : avg_v;
        bias    = ((POOL_W+1)'(1) << shift) >> 1;
        rounded = ($signed({act_v[POOL_W-1], act_v}) + $signed(bias)) >>> shift;
        if (rounded > SAT_HI)      q = SAT_HI[OUT_W-1:0];
        else if (rounded < SAT_LO) q = SAT_LO[OUT_W-1:0];
        else                       q = rounded[OUT_W-1:0];
    end

endmodule

// File: rtl/feature_combine_unit.sv
module feature_combine_unit
    import fcu_pkg::*;
#(
    parameter int N_KER = 4,
    parameter int RES_W = 18,
    parameter int ACC_W = 32,
    parameter int LOG_W = 2,
    parameter int SH_W  = 4,
    parameter int OUT_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [N_KER*4*RES_W-1:0]     in_data,
    input  logic                         in_pass_last,
    input  logic                         in_win_last,
    input  logic [1:0]                   cfg_group,
    input  logic [1:0]                   cfg_pool,
    input  logic [LOG_W-1:0]             cfg_pool_log2,
    input  logic                         cfg_relu,
    input  logic [SH_W-1:0]              cfg_shift,
    output logic                         out_valid,
    output logic [N_KER*4*OUT_W-1:0]     out_data
);

    localparam int N_CL    = 4;
    localparam int N_LANE  = N_KER * N_CL;
    localparam int SUM_W   = RES_W + 2;
    localparam int MAX_LOG = (1 << LOG_W) - 1;
    localparam int POOL_W  = ACC_W + MAX_LOG;

    logic use_acc, use_pool, acc_load, pool_load, emit;
    logic pool_on, avg_en, max_en;

    assign max_en  = (cfg_pool == POOL_MAX);
    assign avg_en  = (cfg_pool == POOL_AVG);
    assign pool_on = max_en || avg_en;

    fcu_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .pass_last (in_pass_last),
        .win_last  (in_win_last),
        .pool_on   (pool_on),
        .use_acc   (use_acc),
        .use_pool  (use_pool),
        .acc_load  (acc_load),
        .pool_load (pool_load),
        .emit      (emit)
    );

    logic [N_LANE*SUM_W-1:0] comb_flat;
    logic [N_LANE*OUT_W-1:0] post_flat;
    logic [N_LANE-1:0]       lane_neg;
    logic [N_LANE-1:0]       side_nz;

    fcu_combine #(.N_KER(N_KER), .RES_W(RES_W), .SUM_W(SUM_W)) u_comb (
        .in_res (in_data),
        .grp    (cfg_group),
        .lanes  (comb_flat)
    );

    for (genvar l = 0; l < N_LANE; l++) begin : g_lane
        logic signed [SUM_W-1:0]  c_v;
        logic signed [ACC_W-1:0]  c_ext, acc_q, total;
        logic signed [POOL_W-1:0] pool_q, cand, pooled;

        assign c_v   = comb_flat[l*SUM_W +: SUM_W];
        assign c_ext = ACC_W'(c_v);

        always_comb begin
            total = use_acc ? (acc_q + c_ext) : c_ext;
            cand  = POOL_W'(total);
            if (use_pool && max_en)      pooled = (pool_q > cand) ? pool_q : cand;
            else if (use_pool && avg_en) pooled = pool_q + cand;
            else                         pooled = cand;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q  <= '0;
                pool_q <= '0;
            end else begin
                if (acc_load)  acc_q  <= total;
                if (pool_load) pool_q <= pooled;
            end
        end

        fcu_post #(.POOL_W(POOL_W), .LOG_W(LOG_W), .SH_W(SH_W), .OUT_W(OUT_W)) u_post (
            .val       (pooled),
            .avg_en    (avg_en),
            .pool_log2 (cfg_pool_log2),
            .relu      (cfg_relu),
            .shift     (cfg_shift),
            .q         (post_flat[l*OUT_W +: OUT_W])
        );

        assign lane_neg[l] = out_data[l*OUT_W + OUT_W - 1];
        if (l % N_CL != 0) begin : g_side
            assign side_nz[l] = |out_data[l*OUT_W +: OUT_W];
        end else begin : g_main
            assign side_nz[l] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= emit;
            if (emit) out_data <= post_flat;
        end
    end

    // R12: an output pulse follows only a final-pass beat
    assert_emit_final_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_pass_last));

    // R6: a final pass that does not close the pooling window stays silent
    assert_mid_window_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && in_pass_last && pool_on && !in_win_last) |-> !out_valid);

    // R4: four-cluster grouping leaves the side lanes at zero
    assert_quad_side_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cfg_group == GRP_QUAD)) |-> (side_nz == '0));

    // R9: ReLU output is never negative
    assert_relu_nonneg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(cfg_relu)) |-> (lane_neg == '0));

endmodule

// File: tb/feature_combine_unit_tb.sv
module feature_combine_unit_tb;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [287:0] in_data;
    logic         in_pass_last, in_win_last;
    logic [1:0]   cfg_group, cfg_pool, cfg_pool_log2;
    logic         cfg_relu;
    logic [3:0]   cfg_shift;
    logic         out_valid;
    logic [127:0] out_data;

    int     n_checks = 0;
    int     n_fail   = 0;
    int     res [4][4];
    longint exp_l [16];
    longint win_l [16];
    longint acc_l [16];

    always #10 clk = ~clk;

    feature_combine_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_pass_last(in_pass_last), .in_win_last(in_win_last),
        .cfg_group(cfg_group), .cfg_pool(cfg_pool), .cfg_pool_log2(cfg_pool_log2),
        .cfg_relu(cfg_relu), .cfg_shift(cfg_shift),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic longint lane_val(int grp, int l);
        int k = l / 4;
        int s = l % 4;
        if (grp == 0) return res[s][k];
        if (grp == 1) begin
            if (s == 0) return res[0][k] + res[1][k];
            if (s == 1) return res[2][k] + res[3][k];
            return 0;
        end
        if (s == 0) return res[0][k] + res[1][k] + res[2][k] + res[3][k];
        return 0;
    endfunction

    function automatic longint rq(longint x, int sh, bit relu);
        longint y;
        if (relu && x < 0) x = 0;
        y = (sh == 0) ? x : ((x + (longint'(1) << (sh - 1))) >>> sh);
        if (y > 127)  y = 127;
        if (y < -128) y = -128;
        return y;
    endfunction

    task automatic check_bit(string req, logic got, logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: out_valid actual=%0b expected=%0b", req, got, exp);
        end
    endtask

    task automatic check_lanes(string req);
        for (int l = 0; l < 16; l++) begin
            longint got = longint'($signed(out_data[l*8 +: 8]));
            n_checks++;
            if (got != exp_l[l]) begin
                n_fail++;
                $display("FAIL %s: lane %0d actual=%0d expected=%0d", req, l, got, exp_l[l]);
            end
        end
    endtask

    task automatic set_cfg(int grp, int pool, int plog, bit relu, int sh);
        cfg_group = 2'(grp); cfg_pool = 2'(pool); cfg_pool_log2 = 2'(plog);
        cfg_relu = relu; cfg_shift = 4'(sh);
    endtask

    task automatic fill(int base, int step);
        for (int c = 0; c < 4; c++)
            for (int k = 0; k < 4; k++)
                res[c][k] = base + step * (c * 4 + k);
    endtask

    // drive at a falling edge, return at the next falling edge with the result visible
    task automatic beat(bit pl, bit wl);
        for (int c = 0; c < 4; c++)
            for (int k = 0; k < 4; k++)
                in_data[(c*4+k)*18 +: 18] = res[c][k][17:0];
        in_pass_last = pl; in_win_last = wl; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_pass_last = 1'b0; in_win_last = 1'b0;
    endtask

    task automatic t_single;
        set_cfg(0, 0, 0, 0, 0);
        fill(-40, 5);
        beat(1, 0);
        check_bit("R12 pulse", out_valid, 1'b1);
        for (int l = 0; l < 16; l++) exp_l[l] = rq(lane_val(0, l), 0, 0);
        check_lanes("R2 per-cluster");
        @(negedge clk);
        check_bit("R12 one cycle", out_valid, 1'b0);
        check_lanes("R12 hold");
    endtask

    task automatic t_pair;
        set_cfg(1, 0, 0, 0, 0);
        fill(-60, 7);
        beat(1, 0);
        for (int l = 0; l < 16; l++) exp_l[l] = rq(lane_val(1, l), 0, 0);
        check_lanes("R3 pairs");
    endtask

    task automatic t_quad;
        set_cfg(2, 0, 0, 0, 0);
        fill(-20, 3);
        beat(1, 0);
        for (int l = 0; l < 16; l++) exp_l[l] = rq(lane_val(2, l), 0, 0);
        check_lanes("R4 quad");
    endtask

    task automatic t_multipass;
        set_cfg(2, 0, 0, 0, 0);
        fill(-20, 3);
        for (int l = 0; l < 16; l++) acc_l[l] = lane_val(2, l);
        beat(0, 0);
        check_bit("R5 no output mid-pass", out_valid, 1'b0);
        fill(1, 1);
        for (int l = 0; l < 16; l++) acc_l[l] += lane_val(2, l);
        beat(0, 1);
        check_bit("R13 win_last on non-final pass", out_valid, 1'b0);
        fill(2, 0);
        for (int l = 0; l < 16; l++) acc_l[l] += lane_val(2, l);
        beat(1, 0);
        check_bit("R5 final pass emits", out_valid, 1'b1);
        for (int l = 0; l < 16; l++) exp_l[l] = rq(acc_l[l], 0, 0);
        check_lanes("R5 accumulated total");
        set_cfg(0, 3, 0, 0, 0);
        fill(9, 1);
        beat(1, 0);
        check_bit("R13 pool code 3 acts as off", out_valid, 1'b1);
        for (int l = 0; l < 16; l++) exp_l[l] = rq(lane_val(0, l), 0, 0);
        check_lanes("R13 pool off");
    endtask

    task automatic t_maxpool;
        set_cfg(0, 1, 0, 0, 0);
        fill(-100, 1);
        for (int l = 0; l < 16; l++) win_l[l] = lane_val(0, l);
        beat(1, 0);
        check_bit("R6 silent 1", out_valid, 1'b0);
        fill(-110, 2);
        for (int l = 0; l < 16; l++) if (lane_val(0, l) > win_l[l]) win_l[l] = lane_val(0, l);
        beat(1, 0);
        check_bit("R6 silent 2", out_valid, 1'b0);
        fill(-90, -3);
        for (int l = 0; l < 16; l++) if (lane_val(0, l) > win_l[l]) win_l[l] = lane_val(0, l);
        beat(1, 1);
        check_bit("R6 emit at window end", out_valid, 1'b1);
        for (int l = 0; l < 16; l++) exp_l[l] = rq(win_l[l], 0, 0);
        check_lanes("R6 max");
        // second window, all values below the first window's maximum
        fill(-125, 1);
        for (int l = 0; l < 16; l++) win_l[l] = lane_val(0, l);
        beat(1, 0);
        fill(-126, 1);
        for (int l = 0; l < 16; l++) if (lane_val(0, l) > win_l[l]) win_l[l] = lane_val(0, l);
        beat(1, 1);
        for (int l = 0; l < 16; l++) exp_l[l] = rq(win_l[l], 0, 0);
        check_lanes("R8 window restart");
    endtask

    task automatic t_avgpool;
        set_cfg(0, 2, 2, 0, 0);
        for (int l = 0; l < 16; l++) win_l[l] = 0;
        for (int b = 0; b < 4; b++) begin
            case (b)
                0: fill(-3, 1);
                1: fill(0, 1);
                2: fill(1, -1);
                default: fill(-4, 2);
            endcase
            for (int l = 0; l < 16; l++) win_l[l] += lane_val(0, l);
            beat(1, b == 3);
            if (b < 3) check_bit("R7 silent", out_valid, 1'b0);
        end
        for (int l = 0; l < 16; l++) exp_l[l] = rq(win_l[l] >>> 2, 0, 0);
        check_lanes("R7 average floor");
    endtask

    task automatic t_relu;
        set_cfg(0, 0, 0, 1, 0);
        fill(-8, 1);
        beat(1, 0);
        for (int l = 0; l < 16; l++) exp_l[l] = rq(lane_val(0, l), 0, 1);
        check_lanes("R9 relu");
    endtask

    task automatic t_round;
        set_cfg(0, 0, 0, 0, 2);
        fill(-8, 1);
        beat(1, 0);
        for (int l = 0; l < 16; l++) exp_l[l] = rq(lane_val(0, l), 2, 0);
        check_lanes("R10 round shift 2");
        set_cfg(0, 0, 0, 0, 5);
        fill(-1000, 131);
        beat(1, 0);
        for (int l = 0; l < 16; l++) exp_l[l] = rq(lane_val(0, l), 5, 0);
        check_lanes("R10 round shift 5");
    endtask

    task automatic t_sat;
        set_cfg(0, 0, 0, 0, 0);
        fill(-300, 40);
        beat(1, 0);
        for (int l = 0; l < 16; l++) exp_l[l] = rq(lane_val(0, l), 0, 0);
        check_lanes("R11 saturate");
    endtask

    task automatic t_same_cycle;
        longint feat [16];
        set_cfg(2, 1, 0, 0, 0);
        fill(5, 1);
        for (int l = 0; l < 16; l++) feat[l] = lane_val(2, l);
        beat(0, 0);
        fill(-10, 0);
        for (int l = 0; l < 16; l++) begin feat[l] += lane_val(2, l); win_l[l] = feat[l]; end
        beat(1, 0);
        check_bit("R6 first feature silent", out_valid, 1'b0);
        fill(-20, 2);
        for (int l = 0; l < 16; l++) feat[l] = lane_val(2, l);
        beat(0, 0);
        check_bit("R5 pass inside window", out_valid, 1'b0);
        fill(3, 1);
        for (int l = 0; l < 16; l++) begin
            feat[l] += lane_val(2, l);
            if (feat[l] > win_l[l]) win_l[l] = feat[l];
        end
        beat(1, 1);
        check_bit("R12 final pass and window end", out_valid, 1'b1);
        for (int l = 0; l < 16; l++) exp_l[l] = rq(win_l[l], 0, 0);
        check_lanes("R5 R6 same-cycle merge");
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
        in_pass_last = 1'b0; in_win_last = 1'b0;
        set_cfg(0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        check_bit("R1 reset valid", out_valid, 1'b0);
        for (int l = 0; l < 16; l++) exp_l[l] = 0;
        check_lanes("R1 reset data");
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1 idle after reset", out_valid, 1'b0);
        t_single();
        t_pair();
        t_quad();
        t_multipass();
        t_maxpool();
        t_avgpool();
        t_relu();
        t_round();
        t_sat();
        t_same_cycle();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule